// File: doc/BRIEF.md
# DSP Multiply-Accumulate Unit

This block keeps a 56-bit signed accumulator next to a 32-bit integer register file. It multiplies signed halfwords, or a full word by a halfword, and either loads the product into the accumulator or adds it to the value already there. It also rounds and saturates the accumulator to word or halfword precision. Move operations copy 32-bit slices of the accumulator to and from the general registers.

A request is a 4-bit operation code and two 32-bit operands, presented with a one-cycle valid strobe. Most operations finish at the clock edge that accepts them. The two rounding operations take a second cycle. While that second cycle is pending the unit shows busy and drops any new request. Read-back data appears on a registered output and stays there until the next read.

Top module: `dsp_mac_unit`

## Requirements
- R1: After reset the accumulator is zero, `rdata_o` is zero, and `busy_o` and `done_o` are low.
- R2: Plain halfword multiply loads the accumulator with the signed 16x16 product, sign-extended to 56 bits. Code 4 takes the upper halves (bits 31..16) of both operands. Code 5 takes the lower halves (bits 15..0).
- R3: Halfword multiply-accumulate adds that same signed product to the accumulator, modulo 2^56. Code 0 uses the upper halves and code 1 uses the lower halves.
- R4: Word-by-halfword operations form the signed product of the whole of `src_a_i` and one halfword of `src_b_i`: the upper halfword for codes 2 and 6, the lower for codes 3 and 7. The product is shifted right arithmetically by 16. Codes 6 and 7 load the result into the accumulator. Codes 2 and 3 add it.
- R5: Read codes 8, 9 and 10 latch bits 63..32, 47..16 and 31..0 of the accumulator sign-extended to 64 bits into `rdata_o`. `rdata_o` holds its value until the next accepted read.
- R6: Code 11 writes `src_a_i[23:0]` into accumulator bits 55..32, so a later high read sign-extends from bit 23 of the written value. Code 12 writes `src_a_i` into bits 31..0 and leaves bits 55..32 unchanged.
- R7: Word rounding (code 13) uses the sign-extended value A and computes T = 2A + 0x8000. T is clamped to the range 0xFFFF8000_00000000 to 0x00007FFF_FFFF0000. If T lies inside the range, its low 16 bits are cleared. The low 56 bits of the result are written back.
- R8: Halfword rounding (code 14) computes T = 2A + 0x8000_0000. T is clamped to the range 0xFFFF8000_00000000 to 0x00007FFF_00000000. If T lies inside the range, its low 32 bits are cleared.
- R9: A rounding operation raises `busy_o` for exactly the one cycle after it is accepted. A request presented while `busy_o` is high is dropped.
- R10: `done_o` pulses for one cycle after each operation completes. For codes 0 to 12 this is the cycle after acceptance. For rounding it is the cycle after `busy_o`.
- R11: Code 15 is reserved. It leaves the accumulator and `rdata_o` unchanged and produces no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| src_a_i | input | 32 | First operand / move source |
| src_b_i | input | 32 | Second operand |
| rdata_o | output | 32 | Latched accumulator slice |
| busy_o | output | 1 | Second rounding step pending |
| done_o | output | 1 | Operation completed |

## Verification
The properties assume that `valid_i` and `op_i` are sampled only at rising edges. They also assume that an operation is counted as accepted only when `valid_i` is high while `busy_o` is low. The stimulus therefore changes inputs on falling edges only. Valid is held for a single cycle, except where the bench deliberately presents an intruding move during the busy cycle of a rounding operation. The bench confirms that the intruder was dropped by reading back all three accumulator slices afterwards.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int ACC_W  = 56;
  localparam int EXT_W  = 64;
  localparam int SAT_W  = ACC_W - 8;

  typedef enum logic [3:0] {
    OP_MAC_HI  = 4'd0,  OP_MAC_LO  = 4'd1,  OP_MAC_WHI = 4'd2,  OP_MAC_WLO = 4'd3,
    OP_MUL_HI  = 4'd4,  OP_MUL_LO  = 4'd5,  OP_MUL_WHI = 4'd6,  OP_MUL_WLO = 4'd7,
    OP_RD_HI   = 4'd8,  OP_RD_MID  = 4'd9,  OP_RD_LO   = 4'd10, OP_WR_HI   = 4'd11,
    OP_WR_LO   = 4'd12, OP_RND_W   = 4'd13, OP_RND_H   = 4'd14, OP_RSVD    = 4'd15
  } mac_op_e;

  typedef enum logic [1:0] {SL_HI = 2'd0, SL_MID = 2'd1, SL_LO = 2'd2} slice_e;

  localparam logic [EXT_W-1:0] ONE_X     = EXT_W'(1);
  localparam logic [EXT_W-1:0] RND_ADD_W = ONE_X << (HALF_W - 1);
  localparam logic [EXT_W-1:0] RND_ADD_H = ONE_X << (WORD_W - 1);
  localparam logic [EXT_W-1:0] POS_LIM   = (ONE_X << (SAT_W - 1)) - ONE_X;
  localparam logic [EXT_W-1:0] MASK_W    = ~((ONE_X << HALF_W) - ONE_X);
  localparam logic [EXT_W-1:0] MASK_H    = ~((ONE_X << WORD_W) - ONE_X);
  localparam logic [EXT_W-1:0] SAT_MAX_W = POS_LIM & MASK_W;
  localparam logic [EXT_W-1:0] SAT_MAX_H = POS_LIM & MASK_H;
  localparam logic [EXT_W-1:0] SAT_MIN   = ~POS_LIM;
endpackage

// File: rtl/dsp_mac_mult.sv
module dsp_mac_mult
  import dsp_mac_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              low_half_i,
  input  logic              word_mode_i,
  output logic [ACC_W-1:0]  prod_o
);
  localparam int HH_W = 2 * HALF_W;
  localparam int WH_W = WORD_W + HALF_W;

  logic signed [HALF_W-1:0] a_h, b_h;
  logic signed [HH_W-1:0]   hh;
  logic signed [WH_W-1:0]   wh, wh_sh;

  assign a_h   = low_half_i ? a_i[HALF_W-1:0] : a_i[WORD_W-1:HALF_W];
  assign b_h   = low_half_i ? b_i[HALF_W-1:0] : b_i[WORD_W-1:HALF_W];
  assign hh    = a_h * b_h;
  assign wh    = $signed(a_i) * b_h;
  assign wh_sh = wh >>> HALF_W;

  always_comb begin
    if (word_mode_i) prod_o = {{(ACC_W-WH_W){wh_sh[WH_W-1]}}, wh_sh};
    else             prod_o = {{(ACC_W-HH_W){hh[HH_W-1]}}, hh};
  end
endmodule

// File: rtl/dsp_mac_round.sv
module dsp_mac_round
  import dsp_mac_pkg::*;
(
  input  logic [EXT_W-1:0] acc_ext_i,
  input  logic             s1_half_i,
  input  logic [EXT_W-1:0] tmp_i,
  input  logic             s2_half_i,
  output logic [EXT_W-1:0] step1_o,
  output logic [ACC_W-1:0] step2_o
);
  logic [EXT_W-1:0] max_lim, mask;
  logic             over, under;

  // step 1: double and add rounding constant
  assign step1_o = (acc_ext_i << 1) + (s1_half_i ? RND_ADD_H : RND_ADD_W);

  // step 2: clamp, then truncate fractional part
  assign max_lim = s2_half_i ? SAT_MAX_H : SAT_MAX_W;
  assign mask    = s2_half_i ? MASK_H : MASK_W;
  assign over    = $signed(tmp_i) > $signed(max_lim);
  assign under   = $signed(tmp_i) < $signed(SAT_MIN);

  always_comb begin
    if (over)       step2_o = max_lim[ACC_W-1:0];
    else if (under) step2_o = SAT_MIN[ACC_W-1:0];
    else            step2_o = tmp_i[ACC_W-1:0] & mask[ACC_W-1:0];
  end
endmodule

// File: rtl/dsp_mac_slice.sv
module dsp_mac_slice
  import dsp_mac_pkg::*;
(
  input  logic [EXT_W-1:0]  acc_ext_i,
  input  slice_e            sel_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int MID_LSB = HALF_W;
  localparam int HI_LSB  = EXT_W - WORD_W;

  always_comb begin
    unique case (sel_i)
      SL_HI:   word_o = acc_ext_i[HI_LSB +: WORD_W];
      SL_MID:  word_o = acc_ext_i[MID_LSB +: WORD_W];
      default: word_o = acc_ext_i[0 +: WORD_W];
    endcase
  end
endmodule

// File: rtl/dsp_mac_unit.sv
module dsp_mac_unit
  import dsp_mac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [WORD_W-1:0] src_a_i,
  input  logic [WORD_W-1:0] src_b_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int UP_W = ACC_W - WORD_W;

  mac_op_e          op;
  logic [ACC_W-1:0] acc_q, prod, sum, step2;
  logic [EXT_W-1:0] acc_ext, tmp_q, step1;
  logic [WORD_W-1:0] rdata_q, slice_w;
  logic             busy_q, done_q, half_q;
  slice_e           slice_sel;

  assign op      = mac_op_e'(op_i);
  assign acc_ext = {{(EXT_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
  assign sum     = acc_q + prod;

  always_comb begin
    unique case (op)
      OP_RD_HI:  slice_sel = SL_HI;
      OP_RD_MID: slice_sel = SL_MID;
      default:   slice_sel = SL_LO;
    endcase
  end

  dsp_mac_mult u_mult (
    .a_i         (src_a_i),
    .b_i         (src_b_i),
    .low_half_i  (op_i[0]),
    .word_mode_i (op_i[1]),
    .prod_o      (prod)
  );

  dsp_mac_round u_round (
    .acc_ext_i (acc_ext),
    .s1_half_i (op == OP_RND_H),
    .tmp_i     (tmp_q),
    .s2_half_i (half_q),
    .step1_o   (step1),
    .step2_o   (step2)
  );

  dsp_mac_slice u_slice (
    .acc_ext_i (acc_ext),
    .sel_i     (slice_sel),
    .word_o    (slice_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      tmp_q   <= '0;
      rdata_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        acc_q  <= step2;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (valid_i) begin
        unique case (op)
          OP_MAC_HI, OP_MAC_LO, OP_MAC_WHI, OP_MAC_WLO: begin
            acc_q  <= sum;
            done_q <= 1'b1;
          end
          OP_MUL_HI, OP_MUL_LO, OP_MUL_WHI, OP_MUL_WLO: begin
            acc_q  <= prod;
            done_q <= 1'b1;
          end
          OP_RD_HI, OP_RD_MID, OP_RD_LO: begin
            rdata_q <= slice_w;
            done_q  <= 1'b1;
          end
          OP_WR_HI: begin
            acc_q[ACC_W-1:WORD_W] <= src_a_i[UP_W-1:0];
            done_q <= 1'b1;
          end
          OP_WR_LO: begin
            acc_q[WORD_W-1:0] <= src_a_i;
            done_q <= 1'b1;
          end
          OP_RND_W, OP_RND_H: begin
            tmp_q  <= step1;
            half_q <= (op == OP_RND_H);
            busy_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dsp_mac_checker.sv
module dsp_mac_checker
  import dsp_mac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [WORD_W-1:0] src_a_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ACC_W-1:0]  acc_i
);
  logic acc_ok, is_rnd, is_rd;
  assign acc_ok = valid_i && !busy_o;
  assign is_rnd = (op_i == OP_RND_W) || (op_i == OP_RND_H);
  assign is_rd  = (op_i == OP_RD_HI) || (op_i == OP_RD_MID) || (op_i == OP_RD_LO);

  assert_round_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && is_rnd) |=> (busy_o && !done_o));

  assert_busy_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o && done_o));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && op_i <= OP_WR_LO) |=> (done_o && !busy_o));

  assert_rdata_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_ok && is_rd) |=> $stable(rdata_o));

  assert_write_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && op_i == OP_WR_LO) |=> (acc_i[WORD_W-1:0] == $past(src_a_i)));

  assert_reserved_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && op_i == OP_RSVD) |=> ($stable(acc_i) && !done_o));
endmodule

bind dsp_mac_unit dsp_mac_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .src_a_i (src_a_i),
  .rdata_o (rdata_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .acc_i   (acc_q)
);

// File: tb/dsp_mac_unit_tb_top.sv
module dsp_mac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] rdata;
  logic        busy, done;

  int n_checks = 0;
  int n_fail   = 0;
  logic [55:0] m_acc = '0;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  dsp_mac_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .src_a_i(a), .src_b_i(b), .rdata_o(rdata), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic longint m_ext();
    return longint'($signed(m_acc));
  endfunction

  function automatic void m_apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    longint p;
    logic signed [15:0] xh, yh;
    xh = o[0] ? x[15:0] : x[31:16];
    yh = o[0] ? y[15:0] : y[31:16];
    if (o[1]) p = (longint'($signed(x)) * longint'(yh)) >>> 16;
    else      p = longint'(xh) * longint'(yh);
    if (o[2]) m_acc = p[55:0];
    else      m_acc = m_acc + p[55:0];
  endfunction

  function automatic void m_round(input bit half);
    longint t, mx, mn, mk;
    mn = 64'shFFFF800000000000;
    mx = half ? 64'sh00007FFF00000000 : 64'sh00007FFFFFFF0000;
    mk = half ? 64'shFFFFFFFF00000000 : 64'shFFFFFFFFFFFF0000;
    t  = (m_ext() <<< 1) + (half ? 64'sh80000000 : 64'sh8000);
    if (t > mx)      t = mx;
    else if (t < mn) t = mn;
    else             t = t & mk;
    m_acc = t[55:0];
  endfunction

  task automatic issue(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    valid = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    valid = 1'b0;
    chk("R10 done", {63'd0, done}, 64'd1);
    if (o <= 4'd7) m_apply(o, x, y);
    else if (o == 4'd11) m_acc[55:32] = x[23:0];
    else if (o == 4'd12) m_acc[31:0] = x;
  endtask

  task automatic read_all(input string req);
    longint e;
    e = m_ext();
    issue(4'd8, '0, '0);  chk({req, " hi"},  {32'd0, rdata}, {32'd0, e[63:32]});
    issue(4'd9, '0, '0);  chk({req, " mid"}, {32'd0, rdata}, {32'd0, e[47:16]});
    issue(4'd10, '0, '0); chk({req, " lo"},  {32'd0, rdata}, {32'd0, e[31:0]});
  endtask

  task automatic load_acc(input logic [31:0] hi, input logic [31:0] lo);
    issue(4'd11, hi, '0);
    issue(4'd12, lo, '0);
  endtask

  task automatic round_op(input bit half, input string req);
    @(negedge clk);
    valid = 1'b1; op = half ? 4'd14 : 4'd13; a = '0; b = '0;
    @(negedge clk);
    chk("R9 busy set", {62'd0, busy, done}, 64'd2);
    op = 4'd12; a = 32'hDEADBEEF;  // intruder while busy
    @(negedge clk);
    valid = 1'b0;
    chk("R10 round done", {62'd0, busy, done}, 64'd1);
    m_round(half);
    read_all(req);
  endtask

  task automatic t_reset();
    chk("R1 busy/done", {62'd0, busy, done}, 64'd0);
    chk("R1 rdata", {32'd0, rdata}, 64'd0);
    read_all("R1 acc zero");
  endtask

  task automatic t_mul_half();
    issue(4'd4, 32'h8000_1234, 32'h7FFF_0002); read_all("R2 mul hi");
    issue(4'd5, 32'h1234_FFFD, 32'h0000_FFF9); read_all("R2 mul lo neg*neg");
  endtask

  task automatic t_mac_half();
    issue(4'd0, 32'h7FFF_0000, 32'h7FFF_0000);
    issue(4'd0, 32'h7FFF_0000, 32'h7FFF_0000); read_all("R3 mac hi");
    issue(4'd1, 32'h0000_8000, 32'h0000_0005); read_all("R3 mac lo");
    load_acc(32'h007F_FFFF, 32'hFFFF_FFFF);
    issue(4'd1, 32'h0000_0001, 32'h0000_0001); read_all("R3 wrap");
  endtask

  task automatic t_word_half();
    issue(4'd6, 32'h1234_5678, 32'hFFFE_0000); read_all("R4 mul whi");
    issue(4'd3, 32'h8000_0000, 32'h0000_7FFF); read_all("R4 mac wlo");
    issue(4'd7, 32'hFFFF_FFFF, 32'h0000_0001); read_all("R4 mul wlo tiny");
    issue(4'd2, 32'h7FFF_FFFF, 32'h8000_0000); read_all("R4 mac whi");
  endtask

  task automatic t_moves();
    load_acc(32'hAB80_0001, 32'h1122_3344); read_all("R6 write hi neg");
    issue(4'd12, 32'hCAFE_F00D, '0);        read_all("R6 write lo keeps hi");
    issue(4'd8, '0, '0);
    issue(4'd0, 32'h0001_0000, 32'h0001_0000);
    chk("R5 rdata hold", {32'd0, rdata}, 64'hFFFF_FFFF_FF80_0001 & 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_round();
    load_acc(32'h0000_0000, 32'h1234_C000); round_op(1'b0, "R7 word normal");
    load_acc(32'h0040_0000, 32'h0000_0000); round_op(1'b0, "R7 word sat pos");
    load_acc(32'h00C0_0000, 32'h0000_0000); round_op(1'b0, "R7 word sat neg");
    load_acc(32'h00FF_FFFF, 32'h9000_0000); round_op(1'b0, "R7 word small neg");
    load_acc(32'h0000_1234, 32'hC000_0000); round_op(1'b1, "R8 half normal");
    load_acc(32'h0000_4000, 32'h0000_0000); round_op(1'b1, "R8 half sat pos");
    load_acc(32'h00FF_0000, 32'h0000_0000); round_op(1'b1, "R8 half sat neg");
    chk("R9 intruder ignored", {32'd0, rdata}, {32'd0, m_ext() & 64'hFFFF_FFFF});
  endtask

  task automatic t_reserved();
    load_acc(32'h0012_3456, 32'h789A_BCDE);
    issue(4'd9, '0, '0);
    @(negedge clk);
    valid = 1'b1; op = 4'd15; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF;
    @(negedge clk);
    valid = 1'b0;
    chk("R11 no done", {63'd0, done}, 64'd0);
    chk("R11 rdata kept", {32'd0, rdata}, {32'd0, m_ext() >> 16} & 64'hFFFF_FFFF);
    read_all("R11 acc kept");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul_half();
    t_mac_half();
    t_word_half();
    t_moves();
    t_round();
    t_reserved();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule